// File: doc/BRIEF.md
# Dual-Mode Pixel Output Formatter

This block sits at the end of a display receiver's pixel path. It accepts decoded 24-bit RGB pixels, one per accepted input cycle, each with a data-enable flag, horizontal and vertical sync and two control bits. It presents them on a registered output port in one of two formats, chosen by a mode input.

In single-pixel mode every pixel leaves on its own on the even bus, and the odd bus stays at zero. In dual-pixel mode an even pixel and the odd pixel after it leave together, on the even and odd buses, at half the pixel rate. A one-cycle clock-enable strobe marks each output update. Pairing follows the pixel's position in the line, so the first active pixel of every line is even. If a line ends on an unpaired even pixel, that pixel is flushed with a zero odd bus. In dual-pixel mode the data-enable, sync and control outputs come from the even pixel of the pair.

Two active-low power-down inputs control tristating. Each drives an output-enable flag rather than a high-impedance value. The full power-down turns off both output groups. The output-drive power-down turns off the main group only, so the sync-detect flag and control bit 0 keep driving.

Top module: `pix_out_fmt`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the pixel buses, data-enable, syncs, control bits and clock-enable strobe are all zero.
- R2: A pixel keeps its colour fields in place: blue in bits 7:0, green in bits 15:8 and red in bits 23:16 of each output bus.
- R3: With `dual_mode` low, each pixel accepted with `in_vld` high appears on `even_q` after that clock edge, with `clk_en` high for that one cycle. `de_q`, `hs_q`, `vs_q` and `ctl_q` carry that pixel's own values.
- R4: With `dual_mode` low, `odd_q` is zero from the edge after that mode is sampled onward.
- R5: With `dual_mode` high, an accepted even pixel produces no strobe. When the next pixel with the same `in_de` value is accepted, `even_q` shows the even pixel and `odd_q` the new one after that edge, with a single `clk_en` pulse.
- R6: In dual-pixel mode, `de_q`, `hs_q`, `vs_q` and `ctl_q` of a pair carry the values of its even pixel.
- R7: The first pixel after any change of `in_de` counts as even, so each active line begins with its pixel 0 on `even_q`.
- R8: In dual-pixel mode, if a held even pixel is followed by a pixel with a different `in_de`, the held pixel is emitted with `odd_q` zero, and the new pixel becomes the next even pixel.
- R9: In any cycle where `clk_en` is low, `even_q`, `de_q`, `hs_q`, `vs_q` and `ctl_q` keep their previous values.
- R10: With `pd_n` low, both `oe_main` and `oe_keep` are low.
- R11: With `pd_n` high and `odpd_n` low, `oe_main` is low and `oe_keep` is high. With both inputs high, both enables are high.
- R12: `det_q` equals the `det_in` value sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 1 = two pixels per output update, 0 = one |
| in_vld | input | 1 | A pixel is offered this cycle |
| in_pix | input | 24 | Pixel: red 23:16, green 15:8, blue 7:0 |
| in_de | input | 1 | Data enable of the offered pixel |
| in_hs | input | 1 | Horizontal sync of the offered pixel |
| in_vs | input | 1 | Vertical sync of the offered pixel |
| in_ctl | input | 2 | Control bits of the offered pixel |
| det_in | input | 1 | Sync-detect flag from the front end |
| pd_n | input | 1 | Full power-down, active low |
| odpd_n | input | 1 | Output-drive power-down, active low |
| clk_en | output | 1 | Output data clock enable, one cycle per update |
| even_q | output | 24 | Even pixel bus |
| odd_q | output | 24 | Odd pixel bus |
| de_q | output | 1 | Registered data enable |
| hs_q | output | 1 | Registered horizontal sync |
| vs_q | output | 1 | Registered vertical sync |
| ctl_q | output | 2 | Registered control bits |
| det_q | output | 1 | Registered sync-detect flag |
| oe_main | output | 1 | Drive enable for pixels, syncs, data enable and ctl_q[1] |
| oe_keep | output | 1 | Drive enable for det_q and ctl_q[0] |

## Verification
A wrong pair phase shows at the first strobe of the next active line. The even bus then carries pixel 1 where pixel 0 belongs, and the pair count of that line is off by one. Both show within one line. A lost flush removes the last even pixel of an odd-length line, and a stuck odd bus in single-pixel mode shows in the very next sampled cycle. A strobe in the wrong cycle shows at once as a changed output without `clk_en`, or as a count mismatch at the end of the line.

// File: rtl/pix_out_fmt.sv
module pix_out_fmt #(
  parameter int COMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dual_mode,
  input  logic                  in_vld,
  input  logic [3*COMP_W-1:0]   in_pix,
  input  logic                  in_de,
  input  logic                  in_hs,
  input  logic                  in_vs,
  input  logic [1:0]            in_ctl,
  input  logic                  det_in,
  input  logic                  pd_n,
  input  logic                  odpd_n,
  output logic                  clk_en,
  output logic [3*COMP_W-1:0]   even_q,
  output logic [3*COMP_W-1:0]   odd_q,
  output logic                  de_q,
  output logic                  hs_q,
  output logic                  vs_q,
  output logic [1:0]            ctl_q,
  output logic                  det_q,
  output logic                  oe_main,
  output logic                  oe_keep
);
  localparam int PIX_W = 3 * COMP_W;

  logic [PIX_W-1:0] h_pix;
  logic             h_de, h_hs, h_vs;
  logic [1:0]       h_ctl;
  logic             phase;
  logic             brk;

  assign brk     = phase && (in_de != h_de);
  assign oe_keep = pd_n;
  assign oe_main = pd_n && odpd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en <= 1'b0;
      even_q <= '0;
      odd_q  <= '0;
      de_q   <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      ctl_q  <= '0;
      det_q  <= 1'b0;
      h_pix  <= '0;
      h_de   <= 1'b0;
      h_hs   <= 1'b0;
      h_vs   <= 1'b0;
      h_ctl  <= '0;
      phase  <= 1'b0;
    end else begin
      det_q  <= det_in;
      clk_en <= 1'b0;
      if (!dual_mode) begin
        phase <= 1'b0;
        odd_q <= '0;
        if (in_vld) begin
          even_q <= in_pix;
          de_q   <= in_de;
          hs_q   <= in_hs;
          vs_q   <= in_vs;
          ctl_q  <= in_ctl;
          clk_en <= 1'b1;
        end
      end else if (in_vld) begin
        if (!phase || brk) begin
          h_pix <= in_pix;
          h_de  <= in_de;
          h_hs  <= in_hs;
          h_vs  <= in_vs;
          h_ctl <= in_ctl;
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
        end
        if (phase) begin
          even_q <= h_pix;
          odd_q  <= brk ? '0 : in_pix;
          de_q   <= h_de;
          hs_q   <= h_hs;
          vs_q   <= h_vs;
          ctl_q  <= h_ctl;
          clk_en <= 1'b1;
        end
      end
    end
  end

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_mode && in_vld) |=> (clk_en && even_q == $past(in_pix)));

  // R4
  odd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dual_mode) |-> (odd_q == '0));

  // R5
  pair_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode && in_vld && !phase) |=> !clk_en);

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode && in_vld && brk) |=> (clk_en && odd_q == '0 && phase));

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> ($stable(even_q) && $stable(de_q) && $stable(hs_q) && $stable(ctl_q)));

  // R12
  det_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (det_q == $past(det_in)));
endmodule

// File: tb/sim_pix_out_fmt.sv
module sim_pix_out_fmt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dual_mode = 1'b0, in_vld = 1'b0, in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [23:0] in_pix = '0;
  logic [1:0]  in_ctl = '0;
  logic        det_in = 1'b0, pd_n = 1'b1, odpd_n = 1'b1;
  logic        clk_en, de_q, hs_q, vs_q, det_q, oe_main, oe_keep;
  logic [23:0] even_q, odd_q;
  logic [1:0]  ctl_q;

  int n_chk = 0, n_bad = 0;
  int mon_line, mon_j, in_line_f, mon_on;
  int len_of [0:63];
  logic [23:0] last_even;
  logic        last_de, last_hs;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_out_fmt u0 (.*);

  function automatic logic [23:0] pix(input int line, input int j);
    return {8'(8'h40 + line), 8'(j * 5 + 3), 8'(line * 11 + j * 3 + 1)};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #2;
    if (rst_n && mon_on != 0) begin
      chk(det_q == det_in, "R12 det_q", 32'(det_q), 32'(det_in));
      if (!dual_mode) chk(odd_q == '0, "R4 odd bus low", odd_q, 0);
      if (!clk_en) begin
        chk(even_q == last_even && de_q == last_de && hs_q == last_hs, "R9 hold",
            even_q, last_even);
      end else if (de_q) begin
        in_line_f = 1;
        chk(even_q[23:16] == pix(mon_line, mon_j)[23:16], "R2 red", even_q[23:16], pix(mon_line, mon_j)[23:16]);
        chk(even_q[15:8] == pix(mon_line, mon_j)[15:8], "R2 green", even_q[15:8], pix(mon_line, mon_j)[15:8]);
        chk(even_q[7:0] == pix(mon_line, mon_j)[7:0], "R2 blue", even_q[7:0], pix(mon_line, mon_j)[7:0]);
        if (dual_mode) begin
          chk(odd_q == ((mon_j + 1 < len_of[mon_line]) ? pix(mon_line, mon_j + 1) : 24'h0),
              "R5 R8 odd bus", odd_q,
              (mon_j + 1 < len_of[mon_line]) ? pix(mon_line, mon_j + 1) : 24'h0);
          chk(ctl_q == 2'(mon_j), "R6 ctl from even pixel", ctl_q, 2'(mon_j));
          mon_j += 2;
        end else begin
          chk(ctl_q == 2'(mon_j), "R3 ctl", ctl_q, 2'(mon_j));
          mon_j += 1;
        end
      end else if (in_line_f != 0) begin
        chk(mon_j == (dual_mode ? len_of[mon_line] + (len_of[mon_line] & 1) : len_of[mon_line]),
            "R7 strobes per line", mon_j, len_of[mon_line]);
        chk(hs_q == 1'b1 && vs_q == mon_line[0], "R6 R3 first blank sync", {hs_q, vs_q}, {1'b1, mon_line[0]});
        in_line_f = 0;
        mon_j = 0;
        mon_line++;
      end else begin
        chk(hs_q == 1'b0, "R6 R3 blank sync", hs_q, 0);
      end
    end
    last_even = even_q;
    last_de = de_q;
    last_hs = hs_q;
  end

  always @(negedge clk) det_in <= cyc[2] ^ cyc[0];

  task automatic push(input logic [23:0] p, input logic de, input logic hs, input logic vs, input logic [1:0] c);
    @(negedge clk);
    in_vld = 1'b1; in_pix = p; in_de = de; in_hs = hs; in_vs = vs; in_ctl = c;
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = 1'b0; in_pix = 24'hdead00; in_de = ~in_de; in_hs = 1'b1;
  endtask

  task automatic run_mode(input logic m);
    int line;
    @(negedge clk);
    rst_n = 1'b0; in_vld = 1'b0; mon_on = 0;
    dual_mode = m;
    repeat (2) @(negedge clk);
    chk(even_q == '0 && odd_q == '0 && clk_en == 1'b0 && de_q == 1'b0 && ctl_q == '0, "R1 reset",
        {clk_en, de_q, even_q[7:0]}, 0);
    mon_line = 0; mon_j = 0; in_line_f = 0;
    last_even = '0; last_de = 1'b0; last_hs = 1'b0;
    rst_n = 1'b1; mon_on = 1;
    line = 0;
    for (int len = 1; len <= 7; len++) begin
      for (int b = 3; b <= 4; b++) begin
        len_of[line] = len;
        for (int j = 0; j < len; j++) begin
          if (((j + line) % 4) == 3) idle();
          push(pix(line, j), 1'b1, 1'b0, line[0], 2'(j));
        end
        for (int k = 0; k < b; k++) begin
          if (k == 1 && line[1]) idle();
          push(24'h0a0b0c ^ 24'(k), 1'b0, k == 0, line[0], 2'b11);
        end
        line++;
      end
    end
    len_of[line] = 0;
    @(negedge clk); in_vld = 1'b0;
    repeat (4) @(negedge clk);
    chk(mon_line == line, "R5 R3 lines seen", mon_line, line);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    run_mode(1'b1);
    run_mode(1'b0);
    mon_on = 0;
    // R10 / R11
    pd_n = 1'b0; odpd_n = 1'b1; #1;
    chk(!oe_main && !oe_keep, "R10 full power-down", {oe_main, oe_keep}, 0);
    pd_n = 1'b0; odpd_n = 1'b0; #1;
    chk(!oe_main && !oe_keep, "R10 both low", {oe_main, oe_keep}, 0);
    pd_n = 1'b1; odpd_n = 1'b0; #1;
    chk(!oe_main && oe_keep, "R11 drive power-down", {oe_main, oe_keep}, 1);
    pd_n = 1'b1; odpd_n = 1'b1; #1;
    chk(oe_main && oe_keep, "R11 normal", {oe_main, oe_keep}, 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule